// File: doc/BRIEF.md
# Linked-Packet Chain DMA Walker

This engine follows a chain of packets held in memory and streams every payload word to one fixed device data port. Software or a sequencer pulses `start` with the byte address of the first header and a direction bit. The walker reads the header, then fetches the words that follow it one at a time and hands each one to the device. It then follows the header's link to the next packet. When a header's link field is all ones, the walk stops and `done` pulses.

A header word holds two fields. The upper eight bits give the payload length in words. The lower 24 bits give the byte address of the next header. Payload addresses start at the header's own address and move by one word per payload word, upward or downward. Each payload address is wrapped into a 2 MB word-aligned window. Memory is read through a request/response port and only one read is in flight at any time. The device port uses a valid/ready handshake and can stall the walker for as long as it needs to. A counter of words delivered is visible so that the cost of the walk can be reported when it finishes.

Top module: `chain_dma_walker`

## Requirements
- R1: A header word is read at the 24-bit address given, unmasked: either `start_addr` or the previous header's link field. Bits 31:24 of the header are the payload word count and bits 23:0 are the link to the next header.
- R2: A header whose link field equals 24'hFFFFFF is the last one. After its payload has been sent, `done` is high for exactly one cycle, and it pulses once per walk.
- R3: The payload address of word k (k from 1) is the header address plus 4·k when `step_down`=0, or minus 4·k when `step_down`=1. After every step the address is ANDed with 24'h1FFFFC, so it wraps inside the window.
- R4: Every payload word read from memory appears unchanged on `dev_data`, exactly once and in read order.
- R5: A header with a count of zero causes no payload read and no device write. The walker goes straight to the linked header, or finishes if the link is 24'hFFFFFF.
- R6: At most one memory read is outstanding. After a request is accepted, `rd_req_valid` stays low until `rd_rsp_valid` returns the data. While a request waits for `rd_req_ready`, `rd_addr` holds steady.
- R7: While `dev_valid` is high and `dev_ready` is low, `dev_valid` stays high and `dev_data` does not change.
- R8: `busy` rises in the cycle after an accepted `start` and stays high through the `done` cycle. It is low afterwards. While `busy` is low, neither `rd_req_valid` nor `dev_valid` is asserted.
- R9: `words_pushed` clears when a start is accepted. It grows by one for each device handshake and holds its value after the walk ends.
- R10: A `start` pulse that arrives while `busy` is high is ignored and does not change the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 24 | Byte address of the first header |
| step_down | input | 1 | 1: payload addresses decrease; 0: increase |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 24 | Byte address of the read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| dev_valid | output | 1 | Device word valid |
| dev_ready | input | 1 | Device accepts the word |
| dev_data | output | 32 | Device word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| words_pushed | output | 16 | Payload words delivered in the current or last walk |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a single read is outstanding and that the request address stays put while it waits. It checks that a stalled device word stays stable, and it covers the one-cycle `done` inside `busy`, the quiet ports while idle, and the counter stepping only on a device handshake. The scoreboard bench shows what no cycle-local property can: the exact address sequence, including header reads and wrap-around at both window edges and above it. It also shows that payload order and content are preserved across several chains, that zero-length packets are skipped, and that a late `start` leaves a running walk untouched.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_FETCH_HDR  = 3'd1,
      ST_FETCH_WORD = 3'd2,
      ST_PUSH_WORD  = 3'd3,
      ST_NEXT       = 3'd4,
      ST_DONE       = 3'd5
   } walk_state_e;
endpackage

// File: rtl/chain_hdr_split.sv
module chain_hdr_split #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8,
   parameter int PTR_W  = 24
) (
   input  logic [DATA_W-1:0] hdr_word,
   output logic [CNT_W-1:0]  hdr_count,
   output logic [PTR_W-1:0]  hdr_link,
   output logic              hdr_last
);
   // count sits in the top bits, link in the bottom bits
   assign hdr_count = hdr_word[DATA_W-1 -: CNT_W];
   assign hdr_link  = hdr_word[PTR_W-1:0];
   assign hdr_last  = (hdr_link == {PTR_W{1'b1}});
endmodule

// File: rtl/chain_addr_step.sv
module chain_addr_step #(
   parameter int                ADDR_W     = 24,
   parameter logic [ADDR_W-1:0] WIN_MASK   = 24'h1FFFFC,
   parameter int                STEP_BYTES = 4
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              down,
   output logic [ADDR_W-1:0] nxt_addr
);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STEP_BYTES);
   localparam bit                FULL_WIN = (WIN_MASK == {ADDR_W{1'b1}});

   logic [ADDR_W-1:0] raw;
   assign raw = down ? (cur_addr - STEP) : (cur_addr + STEP);

   generate
      if (FULL_WIN) begin : g_plain
         assign nxt_addr = raw;
      end else begin : g_window
         assign nxt_addr = raw & WIN_MASK;
      end
   endgenerate
endmodule

// File: rtl/chain_push_count.sv
module chain_push_count #(
   parameter int CNT_OUT_W = 16,
   parameter bit SATURATE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 inc,
   output logic [CNT_OUT_W-1:0] count
);
   logic at_max;
   assign at_max = (count == {CNT_OUT_W{1'b1}});

   logic do_inc;
   generate
      if (SATURATE) begin : g_sat
         assign do_inc = inc && !at_max;
      end else begin : g_wrap
         assign do_inc = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (do_inc) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/chain_walk_fsm.sv
module chain_walk_fsm
   import chain_dma_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              step_down,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_rsp_valid,
   input  logic [DATA_W-1:0] rd_rsp_data,
   output logic              dev_valid,
   input  logic              dev_ready,
   output logic [DATA_W-1:0] dev_data,
   output logic              busy,
   output logic              done,
   input  logic [CNT_W-1:0]  hdr_count,
   input  logic [ADDR_W-1:0] hdr_link,
   input  logic              hdr_last,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              down,
   input  logic [ADDR_W-1:0] step_addr,
   output logic              start_take,
   output logic              push_fire
);
   walk_state_e       state;
   logic              req_sent;
   logic [ADDR_W-1:0] hdr_addr_q;
   logic [ADDR_W-1:0] link_q;
   logic              last_q;
   logic [CNT_W-1:0]  remain_q;
   logic [DATA_W-1:0] data_q;

   logic fetching;
   logic req_fire;
   logic rsp_take;

   assign fetching   = (state == ST_FETCH_HDR) || (state == ST_FETCH_WORD);
   assign rd_req_valid = fetching && !req_sent;
   assign rd_addr    = (state == ST_FETCH_WORD) ? step_addr : hdr_addr_q;
   assign req_fire   = rd_req_valid && rd_req_ready;
   assign rsp_take   = fetching && req_sent && rd_rsp_valid;

   assign dev_valid  = (state == ST_PUSH_WORD);
   assign dev_data   = data_q;
   assign push_fire  = dev_valid && dev_ready;

   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);
   assign start_take = (state == ST_IDLE) && start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         req_sent   <= 1'b0;
         hdr_addr_q <= '0;
         cur_addr   <= '0;
         link_q     <= '0;
         last_q     <= 1'b0;
         remain_q   <= '0;
         data_q     <= '0;
         down       <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  hdr_addr_q <= start_addr;
                  down       <= step_down;
                  req_sent   <= 1'b0;
                  state      <= ST_FETCH_HDR;
               end
            end
            ST_FETCH_HDR: begin
               if (req_fire) begin
                  req_sent <= 1'b1;
               end
               if (rsp_take) begin
                  req_sent <= 1'b0;
                  cur_addr <= hdr_addr_q;
                  link_q   <= hdr_link;
                  last_q   <= hdr_last;
                  remain_q <= hdr_count;
                  state    <= (hdr_count == '0) ? ST_NEXT : ST_FETCH_WORD;
               end
            end
            ST_FETCH_WORD: begin
               if (req_fire) begin
                  req_sent <= 1'b1;
                  cur_addr <= step_addr;
               end
               if (rsp_take) begin
                  req_sent <= 1'b0;
                  data_q   <= rd_rsp_data;
                  state    <= ST_PUSH_WORD;
               end
            end
            ST_PUSH_WORD: begin
               if (dev_ready) begin
                  remain_q <= remain_q - 1'b1;
                  state    <= (remain_q == CNT_W'(1)) ? ST_NEXT : ST_FETCH_WORD;
               end
            end
            ST_NEXT: begin
               if (last_q) begin
                  state <= ST_DONE;
               end else begin
                  hdr_addr_q <= link_q;
                  state      <= ST_FETCH_HDR;
               end
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker #(
   parameter int                DATA_W     = 32,
   parameter int                CNT_W      = 8,
   parameter int                ADDR_W     = 24,
   parameter logic [ADDR_W-1:0] WIN_MASK   = 24'h1FFFFC,
   parameter int                STEP_BYTES = 4,
   parameter int                PUSH_CNT_W = 16,
   parameter bit                PUSH_SAT   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W-1:0]     start_addr,
   input  logic                  step_down,
   output logic                  rd_req_valid,
   input  logic                  rd_req_ready,
   output logic [ADDR_W-1:0]     rd_addr,
   input  logic                  rd_rsp_valid,
   input  logic [DATA_W-1:0]     rd_rsp_data,
   output logic                  dev_valid,
   input  logic                  dev_ready,
   output logic [DATA_W-1:0]     dev_data,
   output logic                  busy,
   output logic                  done,
   output logic [PUSH_CNT_W-1:0] words_pushed
);
   localparam int ALIGN_BITS = $clog2(STEP_BYTES);

   generate
      if (CNT_W + ADDR_W != DATA_W) begin : g_bad_split
         $error("header count and link widths must fill the data word");
      end
      if ((1 << ALIGN_BITS) != STEP_BYTES) begin : g_bad_step
         $error("STEP_BYTES must be a power of two");
      end
      if (WIN_MASK[ALIGN_BITS-1:0] != '0) begin : g_bad_mask
         $error("WIN_MASK must clear the word offset bits");
      end
      if (PUSH_CNT_W < 1) begin : g_bad_cnt
         $error("PUSH_CNT_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0]  hdr_count;
   logic [ADDR_W-1:0] hdr_link;
   logic              hdr_last;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] step_addr;
   logic              down;
   logic              start_take;
   logic              push_fire;

   chain_hdr_split #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PTR_W  (ADDR_W)
   ) u_split (
      .hdr_word  (rd_rsp_data),
      .hdr_count (hdr_count),
      .hdr_link  (hdr_link),
      .hdr_last  (hdr_last)
   );

   chain_addr_step #(
      .ADDR_W     (ADDR_W),
      .WIN_MASK   (WIN_MASK),
      .STEP_BYTES (STEP_BYTES)
   ) u_step (
      .cur_addr (cur_addr),
      .down     (down),
      .nxt_addr (step_addr)
   );

   chain_walk_fsm #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_addr   (start_addr),
      .step_down    (step_down),
      .rd_req_valid (rd_req_valid),
      .rd_req_ready (rd_req_ready),
      .rd_addr      (rd_addr),
      .rd_rsp_valid (rd_rsp_valid),
      .rd_rsp_data  (rd_rsp_data),
      .dev_valid    (dev_valid),
      .dev_ready    (dev_ready),
      .dev_data     (dev_data),
      .busy         (busy),
      .done         (done),
      .hdr_count    (hdr_count),
      .hdr_link     (hdr_link),
      .hdr_last     (hdr_last),
      .cur_addr     (cur_addr),
      .down         (down),
      .step_addr    (step_addr),
      .start_take   (start_take),
      .push_fire    (push_fire)
   );

   chain_push_count #(
      .CNT_OUT_W (PUSH_CNT_W),
      .SATURATE  (PUSH_SAT)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_take),
      .inc   (push_fire),
      .count (words_pushed)
   );
endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 24,
   parameter int PUSH_CNT_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  rd_req_valid,
   input logic                  rd_req_ready,
   input logic [ADDR_W-1:0]     rd_addr,
   input logic                  rd_rsp_valid,
   input logic                  dev_valid,
   input logic                  dev_ready,
   input logic [DATA_W-1:0]     dev_data,
   input logic                  busy,
   input logic                  done,
   input logic [PUSH_CNT_W-1:0] words_pushed
);
   logic in_flight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_flight <= 1'b0;
      else if (rd_req_valid && rd_req_ready) in_flight <= 1'b1;
      else if (rd_rsp_valid) in_flight <= 1'b0;
   end

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> !rd_req_valid); // R6
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr))); // R6
   AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_data))); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R8
   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req_valid && !dev_valid)); // R8
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid && dev_ready && words_pushed != {PUSH_CNT_W{1'b1}})
      |=> (words_pushed == $past(words_pushed) + 1'b1)); // R9
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(dev_valid && dev_ready) && !(start && !busy)) |=> $stable(words_pushed)); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R10
endmodule

bind chain_dma_walker chain_dma_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .PUSH_CNT_W (PUSH_CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .rd_req_valid (rd_req_valid),
   .rd_req_ready (rd_req_ready),
   .rd_addr      (rd_addr),
   .rd_rsp_valid (rd_rsp_valid),
   .dev_valid    (dev_valid),
   .dev_ready    (dev_ready),
   .dev_data     (dev_data),
   .busy         (busy),
   .done         (done),
   .words_pushed (words_pushed)
);

// File: tb/sim_chain_dma_walker.sv
module sim_chain_dma_walker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] start_addr = '0;
   logic        step_down = 1'b0;
   logic        rd_req_valid;
   logic        rd_req_ready = 1'b0;
   logic [23:0] rd_addr;
   logic        rd_rsp_valid = 1'b0;
   logic [31:0] rd_rsp_data = '0;
   logic        dev_valid;
   logic        dev_ready = 1'b0;
   logic [31:0] dev_data;
   logic        busy;
   logic        done;
   logic [15:0] words_pushed;

   always #(CLK_PERIOD/2) clk = ~clk;

   chain_dma_walker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .step_down(step_down), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_data(dev_data),
      .busy(busy), .done(done), .words_pushed(words_pushed)
   );

   int total = 0;
   int bad = 0;
   logic [31:0] mem [bit [23:0]];
   logic [23:0] exp_addr[$];
   bit          exp_hdr[$];
   logic [31:0] exp_data[$];
   int          done_cnt = 0;
   bit          hold_dev = 1'b0;
   bit          finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] step(input logic [23:0] a, input bit dn);
      logic [23:0] r;
      r = dn ? (a - 24'd4) : (a + 24'd4);
      return r & 24'h1FFFFC;
   endfunction

   function automatic logic [31:0] mem_rd(input logic [23:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'hBAD00000;
   endfunction

   // driver: place one packet in memory and queue the expected stream
   task automatic add_pkt(input logic [23:0] hdr, input int cnt,
                          input logic [23:0] link, input bit dn);
      logic [23:0] a;
      mem[hdr] = {8'(cnt), link};
      exp_addr.push_back(hdr);
      exp_hdr.push_back(1'b1);
      a = hdr;
      for (int i = 0; i < cnt; i++) begin
         logic [31:0] v;
         a = step(a, dn);
         v = {a[7:0] ^ 8'hA5, a} + 32'(i);
         mem[a] = v;
         exp_addr.push_back(a);
         exp_hdr.push_back(1'b0);
         exp_data.push_back(v);
      end
   endtask

   // responder and monitor
   initial begin
      logic [15:0] lfsr;
      bit          pend;
      logic [23:0] pend_addr;
      int          lat;
      bit          prev_stall;
      logic [31:0] prev_data;
      int          cyc;
      lfsr = 16'hACE1; pend = 0; pend_addr = '0; lat = 0;
      prev_stall = 0; prev_data = '0; cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000 && !finished) begin
            chk(1'b0, "WATCHDOG", "run hung", 32'(cyc), 32'd150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (pend && lat == 0) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem_rd(pend_addr);
            pend = 0;
         end else begin
            rd_rsp_valid = 1'b0;
            rd_rsp_data  = 32'h0;
            if (pend) lat--;
         end
         rd_req_ready = lfsr[0] | lfsr[3];
         dev_ready    = hold_dev ? 1'b0 : (lfsr[1] | lfsr[5]);
         #1;
         if (!rst_n) begin
            prev_stall = 0;
         end else begin
            if (prev_stall) begin
               chk(dev_valid, "R7", "valid dropped during stall", 32'(dev_valid), 32'd1);
               chk(dev_data == prev_data, "R7", "data moved during stall", dev_data, prev_data);
            end
            prev_stall = dev_valid && !dev_ready;
            prev_data  = dev_data;
            if (rd_req_valid && rd_req_ready) begin
               if (exp_addr.size() == 0) begin
                  chk(1'b0, "R5", "unexpected read", 32'(rd_addr), 32'h0);
               end else begin
                  logic [23:0] ea;
                  bit          eh;
                  ea = exp_addr.pop_front();
                  eh = exp_hdr.pop_front();
                  chk(rd_addr == ea, eh ? "R1" : "R3", eh ? "header address" : "payload address",
                      32'(rd_addr), 32'(ea));
               end
               pend = 1;
               pend_addr = rd_addr;
               lat = (lfsr[7:6] == 2'd3) ? 0 : int'(lfsr[7:6]);
            end
            if (dev_valid && dev_ready) begin
               if (exp_data.size() == 0) begin
                  chk(1'b0, "R4", "extra device word", dev_data, 32'h0);
               end else begin
                  logic [31:0] ed;
                  ed = exp_data.pop_front();
                  chk(dev_data == ed, "R4", "device word", dev_data, ed);
               end
            end
            if (done) done_cnt++;
         end
      end
   end

   task automatic run_chain(input logic [23:0] a, input bit dn, input int nwords,
                            input bit hold, input bit restart);
      int cyc;
      done_cnt = 0;
      @(negedge clk);
      start_addr = a; step_down = dn; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #2;
      chk(busy, "R8", "busy after start", 32'(busy), 32'd1);
      chk(words_pushed == 16'd0, "R9", "count cleared on start", 32'(words_pushed), 32'd0);
      if (restart) begin
         repeat (3) @(negedge clk);
         start_addr = 24'h1FFFF8; step_down = ~dn; start = 1'b1; // R10: ignored
         @(negedge clk);
         start = 1'b0;
      end
      if (hold) begin
         hold_dev = 1'b1;
         repeat (40) @(negedge clk);
         hold_dev = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         #2;
         cyc++;
      end
      chk(done, "R2", "done seen", 32'(done), 32'd1);
      chk(busy, "R8", "busy during done", 32'(busy), 32'd1);
      chk(words_pushed == 16'(nwords), "R9", "words at done", 32'(words_pushed), 32'(nwords));
      chk(exp_addr.size() == 0, "R3", "reads left over", 32'(exp_addr.size()), 32'd0);
      chk(exp_data.size() == 0, "R4", "words left over", 32'(exp_data.size()), 32'd0);
      @(negedge clk);
      #2;
      chk(!done, "R2", "done one cycle", 32'(done), 32'd0);
      chk(!busy, "R8", "busy after done", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
      #2;
      chk(done_cnt == 1, "R2", "done pulses per walk", 32'(done_cnt), 32'd1);
      chk(words_pushed == 16'(nwords), "R9", "count held", 32'(words_pushed), 32'(nwords));
      chk(!rd_req_valid && !dev_valid, "R8", "quiet when idle",
          32'({rd_req_valid, dev_valid}), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk(!busy && !done, "R8", "reset busy/done", 32'({busy, done}), 32'd0);
      chk(!rd_req_valid && !dev_valid, "R6", "reset requests", 32'({rd_req_valid, dev_valid}), 32'd0);
      chk(words_pushed == 16'd0, "R9", "reset count", 32'(words_pushed), 32'd0);
      rst_n = 1'b1;

      // chain up, middle packet empty (R5), late start ignored (R10)
      mem.delete();
      add_pkt(24'h001000, 3, 24'h002000, 1'b0);
      add_pkt(24'h002000, 0, 24'h003000, 1'b0);
      add_pkt(24'h003000, 2, 24'hFFFFFF, 1'b0);
      run_chain(24'h001000, 1'b0, 5, 1'b0, 1'b1);

      // chain down with device stall (R7)
      mem.delete();
      add_pkt(24'h010100, 4, 24'h020000, 1'b1);
      add_pkt(24'h020000, 1, 24'hFFFFFF, 1'b1);
      run_chain(24'h010100, 1'b1, 5, 1'b1, 1'b0);

      // R3 wrap at the top of the window
      mem.delete();
      add_pkt(24'h1FFFF8, 3, 24'hFFFFFF, 1'b0);
      run_chain(24'h1FFFF8, 1'b0, 3, 1'b0, 1'b0);

      // R3 wrap below zero
      mem.delete();
      add_pkt(24'h000008, 4, 24'hFFFFFF, 1'b1);
      run_chain(24'h000008, 1'b1, 4, 1'b0, 1'b0);

      // R5 single empty last packet
      mem.delete();
      add_pkt(24'h005000, 0, 24'hFFFFFF, 1'b0);
      run_chain(24'h005000, 1'b0, 0, 1'b0, 1'b0);

      // R1 header above the window, payload masked (R3)
      mem.delete();
      add_pkt(24'hE00010, 2, 24'h300040, 1'b0);
      add_pkt(24'h300040, 1, 24'hFFFFFF, 1'b0);
      run_chain(24'hE00010, 1'b0, 3, 1'b0, 1'b0);

      // R1 largest count
      mem.delete();
      add_pkt(24'h040000, 255, 24'hFFFFFF, 1'b0);
      run_chain(24'h040000, 1'b0, 255, 1'b0, 1'b0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule